// File: doc/BRIEF.md
# Write-Protected Clock Register File

This block is the byte-wide register store of a real-time-clock device, placed behind a byte-level bus-slave front end that has already decoded the serial traffic. The front end delivers four events: a transaction start (also used for a repeated start), a written byte with its data, a request for one read byte, and a transaction stop. Each write transaction opens with two address bytes. The first must be zero and the second selects one of 64 byte registers. Any further bytes are data, stored at the pointer, and the pointer advances after each one. Reads return the byte at the pointer and advance it as well, so a host can fetch a block of time or alarm bytes in one burst after a pointer write and a repeated start.

Every register except the status register is write-protected. A host arms the file in two steps on the status register: first the latch value, then the value with both enable bits. Until then, data writes to protected registers are accepted on the bus and thrown away. The status register also holds a clock-failure flag. Reset and an external power-fail input set this flag, and an armed write into the clock block clears it.

Top module: `wp_rtc_regs`

## Requirements
- R1: After reset the pointer is 0x00, every storage byte reads 0x00, and the status register (address 0x3F) reads 0x01: bit 0 (clock failure) is set, and bit 1 (write-enable latch) and bit 2 (register write enable) are clear.
- R2: After a start, the first written byte is the high address and the second is the low address, which loads the pointer. If the high byte is not 0x00, or the low byte is above 0x3F, the pointer is left unchanged and every data byte of that transaction is discarded.
- R3: Each data byte after the two address bytes is written at the pointer, and the pointer then advances by one. It wraps from 0x3F to 0x00.
- R4: Writing 0x02 to the status register sets bit 1 only. Writing 0x06 while bit 1 is already set sets both bit 1 and bit 2, and the file is then armed.
- R5: Writing 0x06 to the status register while bit 1 is clear leaves both bits clear. Writing any value other than 0x02 or 0x06, including 0x00, clears both bits. Status writes never change bit 0.
- R6: While the file is not armed, data writes to any address other than 0x3F are acknowledged, change no register and still advance the pointer.
- R7: A read request makes rd_data carry the byte at the pointer, with rd_valid high, on the clock after the request. The pointer then advances by one and wraps from 0x3F to 0x00. rd_valid is low in every other cycle.
- R8: A repeated start keeps the pointer, so bytes read after it continue from the address just written. Reads never need arming.
- R9: Bits 7 to 3 of the status register always read as zero. Address 0x10 always reads as 0x00, even after an armed write to it.
- R10: An armed data write to an address from 0x30 to 0x37 clears status bit 0. A high pwr_fail sets bit 0 on the next clock, and it takes priority over a clear in the same cycle.
- R11: A stop, or a new start, returns the byte counter to the high-address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated start of a transaction |
| bus_stop | input | 1 | End of transaction |
| bus_wr | input | 1 | One written byte is present on bus_wdata |
| bus_wdata | input | 8 | Written byte |
| bus_rd | input | 1 | Request for one read byte |
| pwr_fail | input | 1 | Power-fail indication; sets the clock-failure flag |
| rd_data | output | 8 | Read byte, registered |
| rd_valid | output | 1 | rd_data is valid this cycle |

## Verification
The register file is driven with directed transactions and then with a long run of random ones. The random run mixes arming, disarming, single writes to arbitrary addresses (the status register included), burst reads from random bases and power-fail pulses. Every read byte is compared with a bench model built from the requirements. This separates writes that were really dropped from writes that landed at the wrong address. It also separates an arming sequence that was honoured from one taken out of order.

The directed cases cover the things random traffic rarely hits:
- a bad high address byte and an out-of-range low address byte;
- a burst write that runs across the status register and wraps to 0x00;
- the 0x06 value written without the latch set;
- the always-zero register;
- a power-fail pulse in the same cycle as an armed clock write.

// File: rtl/wp_rtc_regs.sv
module wp_rtc_regs #(
  parameter int AW          = 6,
  parameter int STATUS_ADDR = 63,
  parameter int ZERO_ADDR   = 16,
  parameter int CLK_BASE    = 48,
  parameter int CLK_COUNT   = 8,
  parameter logic [7:0] ARM1_VAL = 8'h02,
  parameter logic [7:0] ARM2_VAL = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  input  logic       pwr_fail,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {PH_HI, PH_LO, PH_DATA, PH_DROP} phase_t;

  phase_t          phase;
  logic [AW-1:0]   ptr;
  logic [7:0]      mem [DEPTH];
  logic            wel, rwel, fail_flag;

  logic do_start, do_stop, do_wr, do_rd;
  assign do_start = bus_start;
  assign do_stop  = !bus_start && bus_stop;
  assign do_wr    = !bus_start && !bus_stop && bus_wr;
  assign do_rd    = !bus_start && !bus_stop && !bus_wr && bus_rd;

  logic armed, at_status, at_zero, at_clock, lo_ok, data_wr;
  assign armed     = wel && rwel;
  assign at_status = int'(ptr) == STATUS_ADDR;
  assign at_zero   = int'(ptr) == ZERO_ADDR;
  assign at_clock  = int'(ptr) >= CLK_BASE && int'(ptr) < CLK_BASE + CLK_COUNT;
  assign lo_ok     = int'(bus_wdata) < DEPTH;
  assign data_wr   = do_wr && phase == PH_DATA;

  logic [7:0] cur_byte;
  always_comb begin
    if (at_status)    cur_byte = {5'b0, rwel, wel, fail_flag};
    else if (at_zero) cur_byte = 8'h00;
    else              cur_byte = mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_HI;
      ptr   <= '0;
    end else if (do_start || do_stop) begin
      phase <= PH_HI;
    end else if (do_wr) begin
      case (phase)
        PH_HI:   phase <= (bus_wdata == 8'h00) ? PH_LO : PH_DROP;
        PH_LO: begin
          if (lo_ok) begin
            phase <= PH_DATA;
            ptr   <= bus_wdata[AW-1:0];
          end else begin
            phase <= PH_DROP;
          end
        end
        PH_DATA: ptr <= ptr + 1'b1;
        default: phase <= PH_DROP;
      endcase
    end else if (do_rd) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (data_wr && armed && !at_status && !at_zero) begin
      mem[ptr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (data_wr && at_status) begin
      if (bus_wdata == ARM1_VAL) begin
        wel  <= 1'b1;
        rwel <= 1'b0;
      end else if (bus_wdata == ARM2_VAL && wel) begin
        wel  <= 1'b1;
        rwel <= 1'b1;
      end else begin
        wel  <= 1'b0;
        rwel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             fail_flag <= 1'b1;
    else if (pwr_fail)                      fail_flag <= 1'b1;
    else if (data_wr && armed && at_clock)  fail_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= cur_byte;
    end
  end
endmodule

// File: rtl/wp_rtc_regs_chk.sv
module wp_rtc_regs_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          pwr_fail,
  input logic          wel,
  input logic          rwel,
  input logic          fail_flag,
  input logic          rd_valid,
  input logic [AW-1:0] ptr
);
  a_r4_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  a_r4_arm_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_start && !bus_stop && !bus_wr) |=> rd_valid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_start && !bus_stop && !bus_wr) |=> ptr == $past(ptr) + 1'b1);

  a_r10_pwr_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> fail_flag);
endmodule

bind wp_rtc_regs wp_rtc_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .pwr_fail(pwr_fail), .wel(wel),
  .rwel(rwel), .fail_flag(fail_flag), .rd_valid(rd_valid), .ptr(ptr)
);

// File: tb/tb_wp_rtc_regs.sv
module tb_wp_rtc_regs;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_start = 0, bus_stop = 0, bus_wr = 0, bus_rd = 0, pwr_fail = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] rd_data;
  logic rd_valid;

  always #10 clk = ~clk;

  wp_rtc_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .pwr_fail(pwr_fail), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int total = 0;
  int bad = 0;

  logic [7:0] m_mem [64];
  logic m_wel, m_rwel, m_fail;
  logic [5:0] m_ptr;

  function automatic logic [7:0] m_read(logic [5:0] a);
    if (a == 6'h3F) return {5'b0, m_rwel, m_wel, m_fail};
    if (a == 6'h10) return 8'h00;
    return m_mem[a];
  endfunction

  function automatic void m_write(logic [5:0] a, logic [7:0] d);
    if (a == 6'h3F) begin
      if (d == 8'h02) begin m_wel = 1; m_rwel = 0; end
      else if (d == 8'h06 && m_wel) begin m_wel = 1; m_rwel = 1; end
      else begin m_wel = 0; m_rwel = 0; end
    end else if (m_wel && m_rwel) begin
      if (a != 6'h10) m_mem[a] = d;
      if (a >= 6'h30 && a <= 6'h37) m_fail = 0;
    end
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic wr_byte(logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_wdata = d; @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd_byte(string tag);
    logic [7:0] e;
    e = m_read(m_ptr);
    @(negedge clk); bus_rd = 1; @(negedge clk); bus_rd = 0;
    chk(tag, rd_data, e);
    chk({tag, " valid"}, {7'b0, rd_valid}, 8'h01);
    m_ptr = m_ptr + 1;
  endtask

  task automatic wr_txn(logic [7:0] hi, logic [7:0] lo, logic [7:0] d[4], int n);
    pulse_start();
    wr_byte(hi);
    wr_byte(lo);
    for (int i = 0; i < n; i++) begin
      wr_byte(d[i]);
      if (hi == 8'h00 && lo < 8'd64) begin
        m_write(m_ptr + 6'(lo) - m_ptr + 6'(i), d[i]);
      end
    end
    if (hi == 8'h00 && lo < 8'd64) m_ptr = 6'(lo) + 6'(n);
    pulse_stop();
  endtask

  task automatic wr_one(logic [7:0] a, logic [7:0] d);
    logic [7:0] b[4];
    b = '{d, 8'h00, 8'h00, 8'h00};
    wr_txn(8'h00, a, b, 1);
  endtask

  task automatic rd_txn(string tag, logic [7:0] a, int n);
    logic [7:0] b[4];
    b = '{8'h00, 8'h00, 8'h00, 8'h00};
    pulse_start();
    wr_byte(8'h00);
    wr_byte(a);
    m_ptr = a[5:0];
    pulse_start();
    for (int i = 0; i < n; i++) rd_byte(tag);
    pulse_stop();
  endtask

  task automatic arm();
    wr_one(8'h3F, 8'h02);
    wr_one(8'h3F, 8'h06);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b[4];
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
    m_wel = 0; m_rwel = 0; m_fail = 1; m_ptr = 0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid low after reset", {7'b0, rd_valid}, 8'h00);

    // R1 reset state; R8 repeated start read without arming
    pulse_start();
    rd_byte("R1 reset pointer byte0");
    rd_txn("R1 R9 status after reset", 8'h3F, 1);
    rd_txn("R1 clock bytes zero", 8'h30, 4);

    // R6 unarmed writes dropped
    wr_one(8'h31, 8'h45);
    rd_txn("R6 unarmed write dropped", 8'h31, 1);

    // R5 0x06 without latch
    wr_one(8'h3F, 8'h06);
    rd_txn("R5 arm step two alone", 8'h3F, 1);

    // R4 arming order
    wr_one(8'h3F, 8'h02);
    rd_txn("R4 latch only", 8'h3F, 1);
    wr_one(8'h3F, 8'h06);
    rd_txn("R4 armed", 8'h3F, 1);

    // R10 armed clock write clears failure flag
    wr_one(8'h32, 8'h23);
    rd_txn("R10 fail cleared", 8'h3F, 1);
    rd_txn("R3 clock byte written", 8'h32, 1);

    // R9 zero register
    wr_one(8'h10, 8'hA5);
    rd_txn("R9 zero register", 8'h10, 1);

    // R2 bad high byte and bad low byte
    b = '{8'h77, 8'h66, 8'h00, 8'h00};
    wr_txn(8'h01, 8'h05, b, 2);
    rd_txn("R2 bad high byte", 8'h05, 2);
    wr_one(8'h05, 8'h11);
    b = '{8'h99, 8'h00, 8'h00, 8'h00};
    wr_txn(8'h00, 8'h45, b, 1);
    pulse_start();
    rd_byte("R2 pointer kept after bad low byte");
    pulse_stop();

    // R3 burst write across status and wrap
    b = '{8'h5A, 8'h06, 8'hC3, 8'h00};
    wr_txn(8'h00, 8'h3E, b, 3);
    rd_txn("R3 R7 burst wrap readback", 8'h3E, 4);

    // R11 stop mid-address then fresh transaction
    pulse_start(); wr_byte(8'h00); pulse_stop();
    wr_one(8'h07, 8'h19);
    rd_txn("R11 phase reset by stop", 8'h07, 1);

    // R10 power fail with simultaneous armed clock write
    pulse_start(); wr_byte(8'h00); wr_byte(8'h33);
    @(negedge clk); bus_wr = 1; bus_wdata = 8'h09; pwr_fail = 1;
    @(negedge clk); bus_wr = 0; pwr_fail = 0;
    m_write(6'h33, 8'h09); m_fail = 1; m_ptr = 6'h34;
    pulse_stop();
    rd_txn("R10 pwr_fail priority", 8'h3F, 1);

    // R5 disarm with 0x00, then R6
    wr_one(8'h3F, 8'h00);
    rd_txn("R5 disarm", 8'h3F, 1);
    wr_one(8'h33, 8'hEE);
    rd_txn("R6 dropped after disarm", 8'h33, 1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: arm();
        1: wr_one(8'h3F, 8'($urandom_range(0, 255)));
        2, 3: wr_one(8'($urandom_range(0, 63)), 8'($urandom_range(0, 255)));
        4: rd_txn("R3 R6 R7 random read", 8'($urandom_range(0, 63)), int'($urandom_range(1, 4)));
        default: begin
          @(negedge clk); pwr_fail = 1; @(negedge clk); pwr_fail = 0;
          m_fail = 1;
          rd_txn("R10 random pwr_fail", 8'h3F, 1);
        end
      endcase
    end
    rd_txn("R9 status final", 8'h3F, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule